// File: doc/BRIEF.md
# Keyed-unlock watchdog timer

This block is a watchdog timer that sits on a simple 32-bit register port. Software must prove it is alive by writing a two-word kick pattern to the command location before a free-running count reaches a programmed limit; if it fails, the block emits a single-cycle reset request and then freezes until the chip reset is applied. The same command location also accepts a different two-word pattern that opens the configuration registers (control, limit and window) for a fixed number of clock cycles. Writes to those registers outside that period are dropped.

An optional early-kick window catches software that kicks too eagerly: when the window value is non-zero, a kick that lands while the count is still below it is treated as a fault. Two read-only status flags in the control word report whether the configuration is currently open and whether a configuration write made during the open period has landed. The register port has no back-pressure: every write completes in the cycle it is presented, and read data is a combinational function of the address.

Top module: `wdt_keyed`

## Requirements
- R1: After reset the control word reads 0x0A0 (enable bit 7 and update bit 5 set), the limit register at offset 0x08 reads 0x400, the window register at offset 0x0C reads 0 and `rst_req` is low.
- R2: Writing 0xC520 and then 0xD928 as consecutive writes to offset 0x04 sets control bit 11 from the next cycle for exactly UNLOCK_CYCLES cycles, after which it returns to 0.
- R3: Writes to offsets 0x00, 0x08 and 0x0C while control bit 11 reads 0 leave those registers unchanged.
- R4: A write to offset 0x00, 0x08 or 0x0C while bit 11 reads 1 is visible on readback from the next cycle and sets control bit 10; bit 10 clears when the next unlock pair completes.
- R5: Writing 0xA602 and then 0xB480 as consecutive writes to offset 0x04 returns the count (read at offset 0x04) to 0 on the next cycle.
- R6: A key pair only counts when its second word is the very next write to offset 0x04; any other value in between cancels the pair, and a second word written alone has no effect.
- R7: While control bit 7 is 1 the count rises by one every cycle; while bit 7 is 0 it holds its value.
- R8: When the count has reached the limit with bit 7 set, `rst_req` is high for exactly one cycle on the following edge; from then on the count is frozen and kicks are ignored until `rst_n` is asserted.
- R9: With a non-zero window and bit 7 set, a completed kick while the count is below the window value raises the same one-cycle `rst_req` and freezes the block as in R8.
- R10: Writing 0x120 to the control word during the open period disables counting and reads back 0x120 in the writable bits (bits 8 and 5 set, bit 7 clear).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| rst_req | output | 1 | One-cycle reset request on timeout or early kick |

## Verification
Every write acts on the rising edge at which the strobe is sampled, so a register, a status flag or the zeroed count is visible on readback in the cycle that follows, and `rst_req` rises on the edge after the count reaches the limit or after the faulting kick. The bench runs a behavioural model that advances on the same edge from the same sampled inputs and compares `rst_req` and the read data for the current address one nanosecond after every rising edge, so no result is read before its edge has passed. Directed reads are placed in the same post-edge slot.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [3:0] OFS_CTRL = 4'h0;
  localparam logic [3:0] OFS_CMD  = 4'h4;
  localparam logic [3:0] OFS_TOUT = 4'h8;
  localparam logic [3:0] OFS_WIN  = 4'hC;

  localparam logic [15:0] KEY_OPEN_A = 16'hC520;
  localparam logic [15:0] KEY_OPEN_B = 16'hD928;
  localparam logic [15:0] KEY_KICK_A = 16'hA602;
  localparam logic [15:0] KEY_KICK_B = 16'hB480;

  localparam int BIT_UPD  = 5;
  localparam int BIT_EN   = 7;
  localparam int BIT_AUX  = 8;
  localparam int BIT_DONE = 10;
  localparam int BIT_OPEN = 11;

  typedef enum logic [1:0] {
    SEQ_IDLE      = 2'd0,
    SEQ_OPEN_HALF = 2'd1,
    SEQ_KICK_HALF = 2'd2
  } seq_t;
endpackage

// File: rtl/wdt_keyseq.sv
module wdt_keyseq
  import wdt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              open_hit,
  output logic              kick_hit
);
  seq_t st_q;

  always_comb begin
    open_hit = cmd_wr && (st_q == SEQ_OPEN_HALF) && (cmd_data == DATA_W'(KEY_OPEN_B));
    kick_hit = cmd_wr && (st_q == SEQ_KICK_HALF) && (cmd_data == DATA_W'(KEY_KICK_B));
  end

  // Any write in the second slot ends the pending pair, hit or miss.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SEQ_IDLE;
    end else if (cmd_wr) begin
      if (st_q == SEQ_IDLE) begin
        if (cmd_data == DATA_W'(KEY_OPEN_A))      st_q <= SEQ_OPEN_HALF;
        else if (cmd_data == DATA_W'(KEY_KICK_A)) st_q <= SEQ_KICK_HALF;
        else                                      st_q <= SEQ_IDLE;
      end else begin
        st_q <= SEQ_IDLE;
      end
    end
  end

  assert_half_then_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && st_q != SEQ_IDLE) |=> (st_q == SEQ_IDLE));
endmodule

// File: rtl/wdt_lockctl.sv
module wdt_lockctl #(
  parameter int UNLOCK_CYCLES = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic open_hit,
  input  logic cfg_taken,
  output logic unlocked,
  output logic applied
);
  localparam int LW = $clog2(UNLOCK_CYCLES + 1);

  logic [LW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked <= 1'b0;
      left_q   <= '0;
    end else if (open_hit) begin
      unlocked <= 1'b1;
      left_q   <= LW'(UNLOCK_CYCLES - 1);
    end else if (unlocked) begin
      if (left_q == '0) unlocked <= 1'b0;
      else              left_q   <= left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         applied <= 1'b0;
    else if (open_hit)  applied <= 1'b0;
    else if (cfg_taken) applied <= 1'b1;
  end

  assert_open_after_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    open_hit |=> unlocked);
  assert_stays_shut_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && !open_hit) |=> !unlocked);
  assert_done_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
    open_hit |=> !applied);
  assert_done_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_taken && !open_hit) |=> applied);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             kick,
  input  logic [CNT_W-1:0] limit,
  input  logic [CNT_W-1:0] window,
  output logic [CNT_W-1:0] count,
  output logic             rst_req,
  output logic             tripped
);
  logic early_kick;

  always_comb early_kick = en && (window != '0) && (count < window);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      rst_req <= 1'b0;
      tripped <= 1'b0;
    end else begin
      rst_req <= 1'b0;
      if (!tripped) begin
        if (kick) begin
          count <= '0;
          if (early_kick) begin
            tripped <= 1'b1;
            rst_req <= 1'b1;
          end
        end else if (en) begin
          if (count >= limit) begin
            tripped <= 1'b1;
            rst_req <= 1'b1;
          end else begin
            count <= count + 1'b1;
          end
        end
      end
    end
  end

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  assert_frozen_after_trip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tripped |=> ($stable(count) && !rst_req));
  assert_hold_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tripped && !en && !kick) |=> $stable(count));
  assert_kick_zeroes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (kick && !tripped) |=> (count == '0));
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
  import wdt_pkg::*;
#(
  parameter int DATA_W        = 32,
  parameter int ADDR_W        = 4,
  parameter int UNLOCK_CYCLES = 128,
  parameter logic [31:0] LIMIT_RESET = 32'h400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rst_req
);
  localparam logic [DATA_W-1:0] CTRL_WMASK =
    (DATA_W'(1) << BIT_EN) | (DATA_W'(1) << BIT_UPD) | (DATA_W'(1) << BIT_AUX);
  localparam logic [DATA_W-1:0] CTRL_RESET =
    (DATA_W'(1) << BIT_EN) | (DATA_W'(1) << BIT_UPD);

  logic [DATA_W-1:0] ctrl_q, limit_q, win_q, count;
  logic sel_ctrl, sel_cmd, sel_tout, sel_win;
  logic cmd_wr, cfg_taken, open_hit, kick_hit, unlocked, applied, tripped;

  always_comb begin
    sel_ctrl  = (bus_addr == ADDR_W'(OFS_CTRL));
    sel_cmd   = (bus_addr == ADDR_W'(OFS_CMD));
    sel_tout  = (bus_addr == ADDR_W'(OFS_TOUT));
    sel_win   = (bus_addr == ADDR_W'(OFS_WIN));
    cmd_wr    = bus_wr && sel_cmd;
    cfg_taken = bus_wr && unlocked && (sel_ctrl || sel_tout || sel_win);
  end

  wdt_keyseq #(.DATA_W(DATA_W)) u_keys (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(bus_wdata),
    .open_hit(open_hit), .kick_hit(kick_hit)
  );

  wdt_lockctl #(.UNLOCK_CYCLES(UNLOCK_CYCLES)) u_lock (
    .clk(clk), .rst_n(rst_n), .open_hit(open_hit), .cfg_taken(cfg_taken),
    .unlocked(unlocked), .applied(applied)
  );

  wdt_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(ctrl_q[BIT_EN]), .kick(kick_hit),
    .limit(limit_q), .window(win_q), .count(count),
    .rst_req(rst_req), .tripped(tripped)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= CTRL_RESET;
      limit_q <= DATA_W'(LIMIT_RESET);
      win_q   <= '0;
    end else if (cfg_taken) begin
      if (sel_ctrl) ctrl_q  <= bus_wdata & CTRL_WMASK;
      if (sel_tout) limit_q <= bus_wdata;
      if (sel_win)  win_q   <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (sel_ctrl)
      bus_rdata = ctrl_q | (DATA_W'(unlocked) << BIT_OPEN) | (DATA_W'(applied) << BIT_DONE);
    else if (sel_cmd)  bus_rdata = count;
    else if (sel_tout) bus_rdata = limit_q;
    else if (sel_win)  bus_rdata = win_q;
  end

  assert_locked_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel_tout && !unlocked) |=> $stable(limit_q));
  assert_locked_ctrl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel_ctrl && !unlocked) |=> $stable(ctrl_q));
  assert_locked_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel_win && !unlocked) |=> $stable(win_q));
  assert_no_req_untripped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> tripped);
endmodule

// File: tb/tb_wdt_keyed.sv
module tb_wdt_keyed;
  localparam int UC = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        rst_req;

  int checks = 0;
  int fails = 0;
  int pulses = 0;
  bit done = 1'b0;

  wdt_keyed #(.DATA_W(32), .ADDR_W(4), .UNLOCK_CYCLES(UC)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req)
  );

  always #2 clk = ~clk;

  // Behavioural reference state
  int unsigned m_cnt, m_lim, m_win, m_ctrl, m_left;
  bit m_unl, m_app, m_trip, m_req;
  int m_pend;

  function automatic int unsigned model_read(input logic [3:0] a);
    case (a)
      4'h0: return m_ctrl | (int'(m_unl) << 11) | (int'(m_app) << 10);
      4'h4: return m_cnt;
      4'h8: return m_lim;
      4'hC: return m_win;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string tag, input int unsigned act, input int unsigned exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    bit hit_o, hit_k, cfg, en;
    if (!rst_n) begin
      m_cnt = 0; m_lim = 32'h400; m_win = 0; m_ctrl = 32'hA0; m_left = 0;
      m_unl = 0; m_app = 0; m_trip = 0; m_req = 0; m_pend = 0;
    end else begin
      hit_o = bus_wr && bus_addr == 4'h4 && m_pend == 1 && bus_wdata == 32'hD928;
      hit_k = bus_wr && bus_addr == 4'h4 && m_pend == 2 && bus_wdata == 32'hB480;
      cfg   = bus_wr && m_unl && (bus_addr == 4'h0 || bus_addr == 4'h8 || bus_addr == 4'hC);
      en    = m_ctrl[7];
      m_req = 0;
      if (!m_trip) begin
        if (hit_k) begin
          if (en && m_win != 0 && m_cnt < m_win) begin m_trip = 1; m_req = 1; end
          m_cnt = 0;
        end else if (en) begin
          if (m_cnt >= m_lim) begin m_trip = 1; m_req = 1; end
          else m_cnt++;
        end
      end
      if (cfg) begin
        if (bus_addr == 4'h0) m_ctrl = bus_wdata & 32'h1A0;
        if (bus_addr == 4'h8) m_lim = bus_wdata;
        if (bus_addr == 4'hC) m_win = bus_wdata;
      end
      if (hit_o) begin m_unl = 1; m_left = UC - 1; m_app = 0; end
      else begin
        if (m_unl) begin
          if (m_left == 0) m_unl = 0; else m_left--;
        end
        if (cfg) m_app = 1;
      end
      if (bus_wr && bus_addr == 4'h4) begin
        if (m_pend == 0) begin
          if (bus_wdata == 32'hC520)      m_pend = 1;
          else if (bus_wdata == 32'hA602) m_pend = 2;
          else                            m_pend = 0;
        end else m_pend = 0;
      end
    end
    #1;
    // Per-cycle comparison covering R7, R8 and R9 timing
    chk("R8 per-cycle rst_req", rst_req, m_req);
    chk("R7 per-cycle readback", bus_rdata, model_read(bus_addr));
    if (rst_req) pulses++;
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(posedge clk);
    #1 d = bus_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    pulses = 0;
  endtask

  task automatic unlock();
    wr(4'h4, 32'hC520); wr(4'h4, 32'hD928);
  endtask

  task automatic kick();
    wr(4'h4, 32'hA602); wr(4'h4, 32'hB480);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired R8 actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    do_reset();
    // R1 reset state
    rd(4'h0, v); chk("R1 ctrl after reset", v, 32'hA0);
    rd(4'h8, v); chk("R1 limit after reset", v, 32'h400);
    rd(4'hC, v); chk("R1 window after reset", v, 0);
    chk("R1 rst_req low", rst_req, 0);

    // R3 locked writes ignored
    wr(4'h8, 32'h10); rd(4'h8, v); chk("R3 limit locked", v, 32'h400);
    wr(4'h0, 32'h0);  rd(4'h0, v); chk("R3 ctrl locked", v, 32'hA0);

    // R6 broken or lone second words
    wr(4'h4, 32'hD928); rd(4'h0, v); chk("R6 lone second word", v[11], 0);
    wr(4'h4, 32'hC520); wr(4'h4, 32'h1234); wr(4'h4, 32'hD928);
    rd(4'h0, v); chk("R6 interrupted pair", v[11], 0);

    // R2 / R4 / R10
    unlock(); rd(4'h0, v); chk("R2 open flag", v[11], 1);
    chk("R4 done flag clear on unlock", v[10], 0);
    wr(4'h0, 32'h120); rd(4'h0, v); chk("R10 ctrl 0x120 with flags", v, 32'hD20);
    rd(4'h4, v); repeat (5) @(posedge clk); rd(4'h4, v2); chk("R7 count holds when off", v2, v);
    wr(4'h8, 32'd40);
    repeat (UC + 5) @(posedge clk);
    rd(4'h0, v); chk("R2 open flag expires", v, 32'h520);
    rd(4'h8, v); chk("R4 limit applied", v, 40);

    // R5 / R7 count runs and kick clears
    unlock(); wr(4'h0, 32'hA0);
    repeat (8) @(posedge clk);
    rd(4'h4, v); chk("R7 count advanced", (v > 5) ? 1 : 0, 1);
    kick(); rd(4'h4, v); chk("R5 count zeroed by kick", (v <= 2) ? 1 : 0, 1);

    // R9 early kick
    unlock(); wr(4'hC, 32'd20); kick();
    repeat (3) @(posedge clk);
    chk("R9 early kick pulses once", pulses, 1);
    rd(4'h4, v); kick(); rd(4'h4, v2); chk("R8 frozen after early kick", v2, v);

    // R8 timeout
    do_reset();
    unlock(); wr(4'h8, 32'd50);
    repeat (70) @(posedge clk);
    chk("R8 one pulse at limit", pulses, 1);
    rd(4'h4, v); chk("R8 count frozen at limit", v, 50);
    kick(); rd(4'h4, v); chk("R8 kick ignored after trip", v, 50);

    // R1 default limit trips from reset
    do_reset();
    repeat (1030) @(posedge clk);
    chk("R1 default limit trip", pulses, 1);
    rd(4'h4, v); chk("R1 frozen at default limit", v, 32'h400);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule